// File: doc/BRIEF.md
# Dual 32-bit Up-Counting Timer Pair

This block is a memory-mapped timer with two independent 32-bit up-counters, a low half and a high half. Each half has a counter register and a period register, plus a two-bit enable-mode field. Both enable fields live in one shared control word. A global control word selects the timer mode and holds a separate reset-release bit for each half. Counting takes place only when the global mode selects two unchained 32-bit timers. When a running half's counter matches its period, that half raises its interrupt output for one cycle. After the match, a periodic half starts again from zero. A one-shot half stops where it is and turns itself off.

Software reaches the block through a simple register bus. The bus has a write strobe, a read strobe, a byte address and a data word. Reads are combinational and return zero when no read strobe is present. Counters may be loaded directly, for example to clear one before it starts. Chained 64-bit operation, prescaling and external clock inputs are not part of this block.

Top module: `twin_timer32`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 except the identification word. Both interrupt outputs are low, both halves are held in reset, and the global mode is 0.
- R2: Offset 0x00 reads the constant identification word (parameter `PERIPH_ID`). Writes to it have no effect.
- R3: Register offsets are as follows: low counter 0x10, high counter 0x14, low period 0x18, high period 0x1C, enable control 0x20, global control 0x24. The low enable field is at control bits 7:6 and the high enable field is at bits 23:22. Global bits 1:0 are the reset releases (bit 0 for low, bit 1 for high) and bits 3:2 are the timer mode. Reads at any other offset, and all reads while the read strobe is low, return 0.
- R4: While a half's release bit is 0, its counter is held at 0. It ignores counter writes and raises no interrupt, whatever its enable mode.
- R5: A released half advances by 1 per cycle only when its enable field is 1 (one-shot) or 2 (periodic) and the timer mode is 1 (unchained). Enable value 0 and reserved value 3 keep the counter still, and so does any other timer mode.
- R6: In periodic mode (enable 2), a counter equal to its period goes to 0 on the next cycle, and the half's interrupt is high for exactly that cycle.
- R7: In one-shot mode (enable 1), a counter equal to its period stays at that value. Its enable field reads back 0 on the next cycle, and one interrupt pulse is produced.
- R8: With a period of 0xFFFFFFFF in periodic mode, the counter reaches 0xFFFFFFFF, wraps to 0 and pulses the interrupt once.
- R9: A write to a released half's counter loads the written value on the next cycle. The write takes priority over counting and over the match at that edge.
- R10: The two halves are independent. Holding, reloading or reconfiguring one half does not change the counting or the interrupts of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, 0 when bus_rd is low |
| irq_lo | output | 1 | One-cycle match pulse of the low half |
| irq_hi | output | 1 | One-cycle match pulse of the high half |

## Verification
The bench targets these corner cases:
- The match itself. A counter that is off by one cycle changes the pulse rate, and the bench counts pulses over a fixed window to catch it.
- The all-ones period. A design that compares with an extra bit, or that wraps early, loses or doubles the pulse on wrap.
- One-shot termination. A design that forgets to clear the field keeps counting past the period.
- The reserved enable code, the non-unchained timer modes, and a half held in reset. Each of these must freeze its counter. A design that decodes only the low bit of a field would count through them.
- Writes to the identification word and to unmapped offsets. Decoding that is too loose would show those writes at read-back.

// File: rtl/tt_pkg.sv
// tt_pkg: shared constants for the dual 32-bit timer.
// Holds the register select indices, the byte offsets, the enable-mode
// encoding and the field positions that software decodes.
package tt_pkg;

    localparam int NHALF    = 2;
    localparam int NSEL     = 7;

    localparam int SEL_ID   = 0;
    localparam int SEL_CNT0 = 1;   // half h uses SEL_CNT0 + h
    localparam int SEL_PRD0 = 3;   // half h uses SEL_PRD0 + h
    localparam int SEL_CTL  = 5;
    localparam int SEL_GCTL = 6;

    localparam logic [7:0] OFS_ID   = 8'h00;
    localparam logic [7:0] OFS_CNT0 = 8'h10;
    localparam logic [7:0] OFS_CNT1 = 8'h14;
    localparam logic [7:0] OFS_PRD0 = 8'h18;
    localparam logic [7:0] OFS_PRD1 = 8'h1C;
    localparam logic [7:0] OFS_CTL  = 8'h20;
    localparam logic [7:0] OFS_GCTL = 8'h24;

    typedef enum logic [1:0] {
        EN_OFF  = 2'd0,
        EN_ONCE = 2'd1,
        EN_LOOP = 2'd2,
        EN_RSVD = 2'd3
    } en_mode_e;

    localparam logic [1:0] GM_UNCHAINED = 2'd1;
    localparam int REL_LSB   = 0;
    localparam int GMODE_LSB = 2;

    // Byte offset of select index k.
    function automatic logic [7:0] sel_offset(input int k);
        case (k)
            SEL_ID:       return OFS_ID;
            SEL_CNT0:     return OFS_CNT0;
            SEL_CNT0 + 1: return OFS_CNT1;
            SEL_PRD0:     return OFS_PRD0;
            SEL_PRD0 + 1: return OFS_PRD1;
            SEL_CTL:      return OFS_CTL;
            SEL_GCTL:     return OFS_GCTL;
            default:      return 8'hFF;
        endcase
    endfunction

    // Least significant bit of the enable field of half h in the control word.
    function automatic int en_lsb(input int h);
        return (h == 0) ? 6 : 22;
    endfunction

endpackage

// File: rtl/tt_decode.sv
// tt_decode: turns the bus address and strobes into one-hot write and
// read selects, one per register.
// Assumes: an exact byte-address match; unaligned or unknown offsets select nothing.
module tt_decode
    import tt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    output logic [NSEL-1:0] wsel,
    output logic [NSEL-1:0] rsel
);

    logic [NSEL-1:0] hit;

    // One address comparator per register.
    for (genvar k = 0; k < NSEL; k++) begin : g_hit
        assign hit[k] = (bus_addr == AW'(sel_offset(k)));
    end

    // Gate the matches with the strobes.
    assign wsel = bus_wr ? hit : '0;
    assign rsel = bus_rd ? hit : '0;

endmodule

// File: rtl/tt_regfile.sv
// tt_regfile: configuration storage (enable fields, periods, releases,
// timer mode) and the read-data multiplexer.
// Assumes: wsel/rsel are one-hot or zero, and once_done clears an enable
// field unless software writes the control word in the same cycle.
module tt_regfile
    import tt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSEL-1:0]            wsel,
    input  logic [NSEL-1:0]            rsel,
    input  logic [DW-1:0]              wdata,
    input  logic [DW-1:0]              id_word,
    input  logic [NHALF-1:0]           once_done,
    input  logic [NHALF-1:0][DW-1:0]   cnt,
    output logic [NHALF-1:0][1:0]      en_mode,
    output logic [NHALF-1:0][DW-1:0]   prd,
    output logic [NHALF-1:0]           rel,
    output logic [1:0]                 gmode,
    output logic [DW-1:0]              rdata
);

    for (genvar h = 0; h < NHALF; h++) begin : g_cfg
        // Enable field: a software write wins, else a finished one-shot clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_mode[h] <= EN_OFF;
            else if (wsel[SEL_CTL])
                en_mode[h] <= wdata[en_lsb(h) +: 2];
            else if (once_done[h])
                en_mode[h] <= EN_OFF;
        end

        // Period register of this half.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prd[h] <= '0;
            else if (wsel[SEL_PRD0 + h])
                prd[h] <= wdata;
        end
    end

    // Global control: reset releases and timer mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel   <= '0;
            gmode <= '0;
        end else if (wsel[SEL_GCTL]) begin
            rel   <= wdata[REL_LSB +: NHALF];
            gmode <= wdata[GMODE_LSB +: 2];
        end
    end

    logic [DW-1:0] ctl_word;
    logic [DW-1:0] gctl_word;

    // Assemble the two composite words as software sees them.
    always_comb begin
        ctl_word  = '0;
        gctl_word = '0;
        for (int h = 0; h < NHALF; h++)
            ctl_word[en_lsb(h) +: 2] = en_mode[h];
        gctl_word[REL_LSB +: NHALF] = rel;
        gctl_word[GMODE_LSB +: 2]   = gmode;
    end

    // Read multiplexer; zero when nothing is selected.
    always_comb begin
        rdata = '0;
        if (rsel[SEL_ID])   rdata = id_word;
        if (rsel[SEL_CTL])  rdata = ctl_word;
        if (rsel[SEL_GCTL]) rdata = gctl_word;
        for (int h = 0; h < NHALF; h++) begin
            if (rsel[SEL_CNT0 + h]) rdata = cnt[h];
            if (rsel[SEL_PRD0 + h]) rdata = prd[h];
        end
    end

endmodule

// File: rtl/tt_half.sv
// tt_half: one 32-bit up-counter with period match, periodic reload,
// one-shot stop and a registered one-cycle interrupt pulse.
// Assumes: priority is release hold, then software load, then the match,
// then counting.
module tt_half
    import tt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rel,
    input  logic          run_ok,
    input  logic [1:0]    en_mode,
    input  logic [DW-1:0] prd,
    input  logic          cnt_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt,
    output logic          irq,
    output logic          once_done
);

    logic active;
    logic hit;

    // Counting is allowed in one-shot or periodic mode when the global mode permits it.
    assign active    = run_ok && ((en_mode == EN_ONCE) || (en_mode == EN_LOOP));
    assign hit       = rel && active && !cnt_wr && (cnt == prd);
    assign once_done = hit && (en_mode == EN_ONCE);

    // Counter register with hold, load, reload and increment.
    always_ff @(posedge clk) begin
        if (!rst_n || !rel)
            cnt <= '0;
        else if (cnt_wr)
            cnt <= wdata;
        else if (hit)
            cnt <= (en_mode == EN_LOOP) ? '0 : cnt;
        else if (active)
            cnt <= cnt + 1'b1;
    end

    // Interrupt pulse, one cycle after the match is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= hit;
    end

endmodule

// File: rtl/twin_timer32.sv
// twin_timer32: register-mapped pair of independent 32-bit up-timers.
// Assumes: single clock domain, synchronous active-low reset; combinational reads.
module twin_timer32
    import tt_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          AW        = 8,
    parameter logic [31:0] PERIPH_ID = 32'h5449_0201
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_lo,
    output logic          irq_hi
);

    logic [NSEL-1:0]          wsel;
    logic [NSEL-1:0]          rsel;
    logic [NHALF-1:0][1:0]    en_mode;
    logic [NHALF-1:0][DW-1:0] prd;
    logic [NHALF-1:0][DW-1:0] cnt;
    logic [NHALF-1:0]         rel;
    logic [NHALF-1:0]         cnt_wr;
    logic [NHALF-1:0]         once_done;
    logic [NHALF-1:0]         irq_vec;
    logic [1:0]               gmode;
    logic                     run_ok;
    logic                     ctl_wr;

    tt_decode #(.AW(AW)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .wsel     (wsel),
        .rsel     (rsel)
    );

    tt_regfile #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wsel      (wsel),
        .rsel      (rsel),
        .wdata     (bus_wdata),
        .id_word   (DW'(PERIPH_ID)),
        .once_done (once_done),
        .cnt       (cnt),
        .en_mode   (en_mode),
        .prd       (prd),
        .rel       (rel),
        .gmode     (gmode),
        .rdata     (bus_rdata)
    );

    assign run_ok = (gmode == GM_UNCHAINED);
    assign ctl_wr = wsel[SEL_CTL];

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign cnt_wr[h] = wsel[SEL_CNT0 + h];

        tt_half #(.DW(DW)) u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .rel       (rel[h]),
            .run_ok    (run_ok),
            .en_mode   (en_mode[h]),
            .prd       (prd[h]),
            .cnt_wr    (cnt_wr[h]),
            .wdata     (bus_wdata),
            .cnt       (cnt[h]),
            .irq       (irq_vec[h]),
            .once_done (once_done[h])
        );
    end

    assign irq_lo = irq_vec[0];
    assign irq_hi = irq_vec[1];

endmodule

// File: rtl/tt_chk.sv
// tt_chk: temporal checks on each timer half, bound into twin_timer32.
module tt_chk
    import tt_pkg::*;
#(
    parameter int DW = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NHALF-1:0]         rel,
    input logic [NHALF-1:0][1:0]    en_mode,
    input logic [1:0]               gmode,
    input logic [NHALF-1:0][DW-1:0] cnt,
    input logic [NHALF-1:0][DW-1:0] prd,
    input logic [NHALF-1:0]         cnt_wr,
    input logic                     ctl_wr,
    input logic [DW-1:0]            wdata,
    input logic [NHALF-1:0]         irq
);

    for (genvar h = 0; h < NHALF; h++) begin : g_chk
        AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !rel[h] |=> (cnt[h] == '0) && !irq[h]); // R4

        AST_FROZEN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
            rel[h] && !cnt_wr[h] && (gmode != GM_UNCHAINED) |=> $stable(cnt[h])); // R5

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            rel[h] && !cnt_wr[h] && (gmode == GM_UNCHAINED)
            && ((en_mode[h] == EN_ONCE) || (en_mode[h] == EN_LOOP)) && (cnt[h] != prd[h])
            |=> (cnt[h] == DW'($past(cnt[h]) + 1'b1)) && !irq[h]); // R5

        AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            rel[h] && !cnt_wr[h] && (gmode == GM_UNCHAINED)
            && (en_mode[h] == EN_LOOP) && (cnt[h] == prd[h])
            |=> (cnt[h] == '0) && irq[h]); // R6

        AST_ONCE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            rel[h] && !cnt_wr[h] && !ctl_wr && (gmode == GM_UNCHAINED)
            && (en_mode[h] == EN_ONCE) && (cnt[h] == prd[h])
            |=> irq[h] && (en_mode[h] == EN_OFF) && $stable(cnt[h])); // R7

        AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            rel[h] && cnt_wr[h] |=> (cnt[h] == $past(wdata)) && !irq[h]); // R9
    end

endmodule

bind twin_timer32 tt_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rel     (rel),
    .en_mode (en_mode),
    .gmode   (gmode),
    .cnt     (cnt),
    .prd     (prd),
    .cnt_wr  (cnt_wr),
    .ctl_wr  (ctl_wr),
    .wdata   (bus_wdata),
    .irq     (irq_vec)
);

// File: tb/twin_timer32_tb.sv
module twin_timer32_tb;

    localparam logic [31:0] TB_ID = 32'h5449_0201;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    twin_timer32 #(.DW(32), .AW(8), .PERIPH_ID(TB_ID)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    always #5 clk = ~clk;   // 100 MHz

    // Behavioural reference model
    logic [31:0] m_cnt [2];
    logic [31:0] m_prd [2];
    logic [1:0]  m_en  [2];
    logic        m_rel [2];
    logic        m_irq [2];
    logic [1:0]  m_gm;

    function automatic logic [31:0] mread(input logic [7:0] a);
        case (a)
            8'h00:   return TB_ID;
            8'h10:   return m_cnt[0];
            8'h14:   return m_cnt[1];
            8'h18:   return m_prd[0];
            8'h1C:   return m_prd[1];
            8'h20:   return (32'(m_en[1]) << 22) | (32'(m_en[0]) << 6);
            8'h24:   return {28'd0, m_gm, m_rel[1], m_rel[0]};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] n_cnt [2];
        logic [1:0]  n_en  [2];
        logic        n_irq [2];
        if (!rst_n) begin
            for (int h = 0; h < 2; h++) begin
                m_cnt[h] = '0; m_prd[h] = '0; m_en[h] = '0;
                m_rel[h] = 1'b0; m_irq[h] = 1'b0;
            end
            m_gm = '0;
        end else begin
            for (int h = 0; h < 2; h++) begin
                logic cw, hit, run;
                cw  = bus_wr && (bus_addr == (h == 0 ? 8'h10 : 8'h14));
                run = (m_gm == 2'd1) && (m_en[h] == 2'd1 || m_en[h] == 2'd2);
                hit = m_rel[h] && run && !cw && (m_cnt[h] == m_prd[h]);
                n_irq[h] = hit;
                if (!m_rel[h])   n_cnt[h] = '0;
                else if (cw)     n_cnt[h] = bus_wdata;
                else if (hit)    n_cnt[h] = (m_en[h] == 2'd2) ? 32'd0 : m_cnt[h];
                else if (run)    n_cnt[h] = m_cnt[h] + 32'd1;
                else             n_cnt[h] = m_cnt[h];
                if (bus_wr && bus_addr == 8'h20)
                    n_en[h] = (h == 0) ? bus_wdata[7:6] : bus_wdata[23:22];
                else if (hit && m_en[h] == 2'd1)
                    n_en[h] = 2'd0;
                else
                    n_en[h] = m_en[h];
            end
            for (int h = 0; h < 2; h++) begin
                m_cnt[h] = n_cnt[h];
                m_en[h]  = n_en[h];
                m_irq[h] = n_irq[h];
            end
            if (bus_wr && bus_addr == 8'h18) m_prd[0] = bus_wdata;
            if (bus_wr && bus_addr == 8'h1C) m_prd[1] = bus_wdata;
            if (bus_wr && bus_addr == 8'h24) begin
                m_rel[0] = bus_wdata[0];
                m_rel[1] = bus_wdata[1];
                m_gm     = bus_wdata[3:2];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            check("R6 R7 irq_lo vs model", 32'(irq_lo), 32'(m_irq[0]));
            check("R6 R7 irq_hi vs model", 32'(irq_hi), 32'(m_irq[1]));
            if (bus_rd) check("R3 rdata vs model", bus_rdata, mread(bus_addr));
            else        check("R3 rdata idle zero", bus_rdata, 32'd0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdmodel(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        check(tag, bus_rdata, mread(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdval(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle_count(input int n, output int c0, output int c1);
        c0 = 0; c1 = 0;
        repeat (n) begin
            @(negedge clk);
            #4;
            c0 += int'(irq_lo);
            c1 += int'(irq_hi);
        end
    endtask

    initial begin
        int c0, c1;
        logic [31:0] va, vb;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_lo after reset", 32'(irq_lo), 32'd0);
        check("R1 irq_hi after reset", 32'(irq_hi), 32'd0);
        rdchk(8'h10, 32'd0, "R1 low counter");
        rdchk(8'h1C, 32'd0, "R1 high period");
        rdchk(8'h20, 32'd0, "R1 control");
        rdchk(8'h24, 32'd0, "R1 global");

        // R2 identification word is read-only
        rdchk(8'h00, TB_ID, "R2 id read");
        wr(8'h00, 32'hDEAD_BEEF);
        rdchk(8'h00, TB_ID, "R2 id after write");

        // R3 unmapped offsets read zero
        wr(8'h30, 32'hFFFF_FFFF);
        rdchk(8'h30, 32'd0, "R3 unmapped 0x30");
        rdchk(8'h04, 32'd0, "R3 unmapped 0x04");
        rdchk(8'h12, 32'd0, "R3 unaligned 0x12");

        // R4 halves held in reset: counter writes ignored, no counting
        wr(8'h24, 32'h4);                 // unchained mode, both held
        wr(8'h10, 32'h123);
        wr(8'h20, 32'h0000_0080);         // low periodic
        idle_count(10, c0, c1);
        rdchk(8'h10, 32'd0, "R4 held counter stays zero");
        check("R4 no irq while held", 32'(c0), 32'd0);
        wr(8'h20, 32'h0);

        // R3 field positions, R9 load, R6 periodic pulse rate
        wr(8'h24, 32'h7);
        rdchk(8'h24, 32'h7, "R3 global readback");
        wr(8'h10, 32'h0000_ABCD);
        rdchk(8'h10, 32'h0000_ABCD, "R9 counter load while disabled");
        wr(8'h10, 32'h0);
        wr(8'h18, 32'd4);
        wr(8'h20, 32'h0000_0080);
        rdchk(8'h20, 32'h0000_0080, "R3 low enable at bits 7:6");
        idle_count(25, c0, c1);
        check("R6 five pulses in 25 cycles, period 4", 32'(c0), 32'd5);
        check("R10 high idle while low runs", 32'(c1), 32'd0);
        rdmodel(8'h10, "R6 low counter vs model");

        // R9 load while running takes priority
        wr(8'h10, 32'd2);
        rdmodel(8'h10, "R9 load while running");

        // R5 other timer modes freeze counting
        wr(8'h24, 32'h3);
        rdval(8'h10, va);
        idle_count(10, c0, c1);
        rdval(8'h10, vb);
        check("R5 frozen in mode 0", vb, va);
        check("R5 no irq in mode 0", 32'(c0), 32'd0);
        wr(8'h24, 32'hF);
        rdval(8'h10, va);
        idle_count(10, c0, c1);
        rdval(8'h10, vb);
        check("R5 frozen in mode 3", vb, va);
        wr(8'h24, 32'h7);

        // R5 reserved enable value on the high half
        wr(8'h20, 32'h00C0_0080);
        rdchk(8'h20, 32'h00C0_0080, "R3 high enable at bits 23:22");
        idle_count(10, c0, c1);
        rdchk(8'h14, 32'd0, "R5 reserved enable does not count");

        // R7 one-shot on the high half
        wr(8'h14, 32'd0);
        wr(8'h1C, 32'd6);
        wr(8'h20, 32'h0040_0080);
        idle_count(20, c0, c1);
        check("R7 exactly one high pulse", 32'(c1), 32'd1);
        rdchk(8'h14, 32'd6, "R7 counter stops at period");
        rdchk(8'h20, 32'h0000_0080, "R7 enable field cleared");

        // R8 all-ones period wraps
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFD);
        wr(8'h20, 32'h0080_0080);
        idle_count(8, c0, c1);
        check("R8 one pulse on wrap", 32'(c1), 32'd1);
        rdmodel(8'h14, "R8 counter after wrap");
        rdval(8'h14, va);
        check("R8 counter wrapped to small value", 32'(va < 32'd16), 32'd1);

        // R10 hold only the high half; the low half continues
        wr(8'h24, 32'h5);
        rdchk(8'h14, 32'd0, "R10 high held at zero");
        idle_count(25, c0, c1);
        check("R10 low keeps pulsing", 32'(c0), 32'd5);
        check("R10 held high has no pulse", 32'(c1), 32'd0);
        wr(8'h24, 32'h7);
        idle_count(12, c0, c1);
        rdmodel(8'h14, "R10 high restarts from zero");
        rdmodel(8'h10, "R10 low counter vs model");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule